// File: doc/BRIEF.md
# Three-Wire Group-Coded Register Loader

This block is the configuration front end of a dual-channel frequency synthesizer. A host shifts a frame into it over three wires: a serial clock, a data line and an enable. The bits collect in one shift register. When the enable rises, the final two bits of the frame are read as a group code. The code selects one of four destination latches: the control word, the channel 1 divider word, the channel 2 divider word or the reference divider word. The three serial lines are asynchronous to the system clock. Each line passes through a synchronizer, and the serial clock and the enable are then edge-detected in the system clock domain.

Each destination has its own frame length. Before any latch is written, the loader compares the number of bits received since the previous enable with the length that the group code calls for. Frames that do not match are discarded. Divider words are also rejected when they are out of range. Words for the two channel dividers are refused until the reference word and the control word have each been accepted once after reset. Three flags report how the most recent frame was handled. The decoded control fields and the divider values are presented as plain outputs. Each divider also has its effective division ratio as an output.

Top module: `tw_reg_loader`

## Requirements
- R1: Each rising edge of `ser_clk` while `ser_en` is low appends the level of `ser_data` to the current frame. The bit received last is GC1 and the bit before it is GC2. {GC2,GC1} = 00 selects the control latch, 10 selects channel 1, 01 selects channel 2 and 11 selects the reference latch.
- R2: A frame is committed on the rising edge of `ser_en`. Serial clock edges while `ser_en` is high do not alter the frame. Each commit restarts the bit count for the next frame.
- R3: A control frame is 14 bits long. In order of arrival it carries: test mode, pump polarity invert, channel 1 pump code (two bits, first bit more significant), channel 1 standby, channel 2 pump code (two bits), channel 2 standby, reference standby, lock-output select (two bits, first bit more significant), filter switch, and then the group code.
- R4: For each channel, the one-hot current select output has bit k set for pump code k: 00 → 0001 (1x), 01 → 0010 (2x), 10 → 0100 (4x), 11 → 1000 (8x).
- R5: A channel frame is 19 bits long. It carries a 5-bit swallow value A, sent least significant bit first, then a 12-bit main value B, sent least significant bit first, then the group code. The ratio output equals 2 × (32 × B + A).
- R6: A reference frame is 14 bits long. It carries a 12-bit value R, sent least significant bit first, then the group code. The ratio output equals 2 × R.
- R7: A frame whose bit count differs from the length its group code requires is discarded, with every latch unchanged, and `err_frame` is set.
- R8: A correctly sized channel frame that arrives before both a reference frame and a control frame have been accepted since reset is discarded, and `err_order` is set.
- R9: A reference frame with R < 3, or a channel frame with B < 3 or B < A, is discarded, and `err_range` is set.
- R10: Every commit updates the three error flags. At most one flag is set, and an accepted frame clears all three. The length check takes precedence over the order check, and the order check takes precedence over the range check.
- R11: After reset, every latched field, value and ratio is zero, each current select is 0001, and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Frame enable; its rising edge commits the frame |
| test_mode | output | 1 | Control: test mode |
| cp_invert | output | 1 | Control: pump polarity invert |
| ch1_cp_code | output | 2 | Channel 1 pump current code |
| ch1_cp_sel | output | 4 | Channel 1 one-hot current select |
| ch1_standby | output | 1 | Channel 1 standby |
| ch2_cp_code | output | 2 | Channel 2 pump current code |
| ch2_cp_sel | output | 4 | Channel 2 one-hot current select |
| ch2_standby | output | 1 | Channel 2 standby |
| ref_standby | output | 1 | Reference divider standby |
| lock_sel | output | 2 | Lock-output source select |
| filt_sw | output | 1 | Loop filter switch |
| ch1_swallow | output | 5 | Channel 1 swallow value A |
| ch1_main | output | 12 | Channel 1 main value B |
| ch1_ratio | output | 18 | Channel 1 ratio 2(32B+A) |
| ch2_swallow | output | 5 | Channel 2 swallow value A |
| ch2_main | output | 12 | Channel 2 main value B |
| ch2_ratio | output | 18 | Channel 2 ratio 2(32B+A) |
| ref_count | output | 12 | Reference value R |
| ref_ratio | output | 13 | Reference ratio 2R |
| err_frame | output | 1 | Last frame had the wrong length |
| err_order | output | 1 | Last frame was a channel word sent too early |
| err_range | output | 1 | Last frame held an out-of-range value |

## Verification
A wrong bit count or a shift register corrupted by clock edges during enable shows up at the next commit. The frame is then either rejected with `err_frame` or lands in the wrong latch, and the outputs show it a few system clocks after the enable rises. A wrong bit ordering inside a field appears at once as a wrong swallow, main or reference value, and as a wrong ratio. A lost record of which words have been accepted shows up at the first channel frame that follows. That frame is either refused although it is legal or accepted although it is too early, and the order flag or the channel outputs reveal this in that same frame.

// File: rtl/twl_pkg.sv
package twl_pkg;

  localparam int CTRL_W = 12;
  localparam int GC_W   = 2;

  typedef enum logic [1:0] {
    GRP_CTRL = 2'b00,
    GRP_CH2  = 2'b01,
    GRP_CH1  = 2'b10,
    GRP_REF  = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    VERD_OK  = 2'd0,
    VERD_LEN = 2'd1,
    VERD_ORD = 2'd2,
    VERD_RNG = 2'd3
  } verdict_e;

  // field order follows arrival order: first bit received is the MSB
  typedef struct packed {
    logic       test;
    logic       cp_inv;
    logic [1:0] cp1;
    logic       sb1;
    logic [1:0] cp2;
    logic       sb2;
    logic       sbr;
    logic [1:0] ld;
    logic       sw;
  } ctrl_t;

endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] lvl_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end

    assign lvl_o[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/twl_shift.sv
module twl_shift #(
  parameter int SR_W  = 19,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             hold,
  input  logic             restart,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [SR_W-1:0]  sr_q,  sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (bit_stb && !hold) begin
      sr_d = {sr_q[SR_W-2:0], bit_val};
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;

  // R2
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(sr_q));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) && !restart |=> (cnt_q == '1));

endmodule

// File: rtl/twl_decode.sv
module twl_decode
  import twl_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 12,
  parameter int R_W   = 12,
  parameter int SR_W  = 19,
  parameter int CNT_W = 5,
  parameter int R_MIN = 3,
  parameter int B_MIN = 3
) (
  input  logic [SR_W-1:0]  sr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             r_seen_i,
  input  logic             c_seen_i,
  output grp_e             grp_o,
  output verdict_e         verdict_o,
  output ctrl_t            ctrl_o,
  output logic [A_W-1:0]   a_o,
  output logic [B_W-1:0]   b_o,
  output logic [R_W-1:0]   r_o
);

  localparam int N_LEN = A_W + B_W + GC_W;
  localparam int R_LEN = R_W + GC_W;
  localparam int C_LEN = CTRL_W + GC_W;

  logic [CNT_W-1:0] need_len;
  logic             is_chan;

  always_comb begin
    grp_o  = grp_e'(sr_i[GC_W-1:0]);
    ctrl_o = ctrl_t'(sr_i[C_LEN-1:GC_W]);
    for (int i = 0; i < A_W; i++) a_o[i] = sr_i[N_LEN-1-i];
    for (int j = 0; j < B_W; j++) b_o[j] = sr_i[N_LEN-1-A_W-j];
    for (int k = 0; k < R_W; k++) r_o[k] = sr_i[R_LEN-1-k];
  end

  always_comb begin
    is_chan = (grp_o == GRP_CH1) || (grp_o == GRP_CH2);
    case (grp_o)
      GRP_CTRL: need_len = CNT_W'(C_LEN);
      GRP_REF:  need_len = CNT_W'(R_LEN);
      default:  need_len = CNT_W'(N_LEN);
    endcase
  end

  always_comb begin
    if (cnt_i != need_len)
      verdict_o = VERD_LEN;
    else if (is_chan && !(r_seen_i && c_seen_i))
      verdict_o = VERD_ORD;
    else if ((grp_o == GRP_REF) && (r_o < R_W'(R_MIN)))
      verdict_o = VERD_RNG;
    else if (is_chan && ((b_o < B_W'(B_MIN)) ||
                         (b_o < {{(B_W-A_W){1'b0}}, a_o})))
      verdict_o = VERD_RNG;
    else
      verdict_o = VERD_OK;
  end

endmodule

// File: rtl/tw_reg_loader.sv
module tw_reg_loader
  import twl_pkg::*;
#(
  parameter int A_W         = 5,
  parameter int B_W         = 12,
  parameter int R_W         = 12,
  parameter int SYNC_STAGES = 2,
  parameter int R_MIN       = 3,
  parameter int B_MIN       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_en,
  output logic             test_mode,
  output logic             cp_invert,
  output logic [1:0]       ch1_cp_code,
  output logic [3:0]       ch1_cp_sel,
  output logic             ch1_standby,
  output logic [1:0]       ch2_cp_code,
  output logic [3:0]       ch2_cp_sel,
  output logic             ch2_standby,
  output logic             ref_standby,
  output logic [1:0]       lock_sel,
  output logic             filt_sw,
  output logic [A_W-1:0]   ch1_swallow,
  output logic [B_W-1:0]   ch1_main,
  output logic [A_W+B_W:0] ch1_ratio,
  output logic [A_W-1:0]   ch2_swallow,
  output logic [B_W-1:0]   ch2_main,
  output logic [A_W+B_W:0] ch2_ratio,
  output logic [R_W-1:0]   ref_count,
  output logic [R_W:0]     ref_ratio,
  output logic             err_frame,
  output logic             err_order,
  output logic             err_range
);

  localparam int N_LEN = A_W + B_W + GC_W;
  localparam int R_LEN = R_W + GC_W;
  localparam int C_LEN = CTRL_W + GC_W;
  localparam int NC_MX = (N_LEN > C_LEN) ? N_LEN : C_LEN;
  localparam int SR_W  = (NC_MX > R_LEN) ? NC_MX : R_LEN;
  localparam int CNT_W = $clog2(SR_W + 2);
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;
  localparam int L_EN  = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  // input synchronizers and edge detection
  logic [2:0] lvl;
  logic       clk_prev_q, en_prev_q;
  logic       bit_rise, en_rise;

  twl_sync #(.LINES(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_q),
    .async_i ({ser_en, ser_data, ser_clk}),
    .lvl_o   (lvl)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      clk_prev_q <= 1'b0;
      en_prev_q  <= 1'b0;
    end else begin
      clk_prev_q <= lvl[L_CLK];
      en_prev_q  <= lvl[L_EN];
    end
  end

  assign bit_rise = lvl[L_CLK] & ~clk_prev_q;
  assign en_rise  = lvl[L_EN]  & ~en_prev_q;

  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;

  twl_shift #(.SR_W(SR_W), .CNT_W(CNT_W)) shift_i (
    .clk     (clk),
    .rst_n   (rst_q),
    .bit_stb (bit_rise),
    .bit_val (lvl[L_DAT]),
    .hold    (lvl[L_EN]),
    .restart (en_rise),
    .sr_o    (sr),
    .cnt_o   (cnt)
  );

  grp_e           dec_grp;
  verdict_e       dec_verd;
  ctrl_t          dec_ctrl;
  logic [A_W-1:0] dec_a;
  logic [B_W-1:0] dec_b;
  logic [R_W-1:0] dec_r;
  logic           r_seen_q, r_seen_d, c_seen_q, c_seen_d;

  twl_decode #(
    .A_W(A_W), .B_W(B_W), .R_W(R_W), .SR_W(SR_W), .CNT_W(CNT_W),
    .R_MIN(R_MIN), .B_MIN(B_MIN)
  ) decode_i (
    .sr_i      (sr),
    .cnt_i     (cnt),
    .r_seen_i  (r_seen_q),
    .c_seen_i  (c_seen_q),
    .grp_o     (dec_grp),
    .verdict_o (dec_verd),
    .ctrl_o    (dec_ctrl),
    .a_o       (dec_a),
    .b_o       (dec_b),
    .r_o       (dec_r)
  );

  // destination latches
  ctrl_t          ctrl_q, ctrl_d;
  logic [A_W-1:0] a1_q, a1_d, a2_q, a2_d;
  logic [B_W-1:0] b1_q, b1_d, b2_q, b2_d;
  logic [R_W-1:0] r_q, r_d;
  logic [2:0]     err_q, err_d;
  logic           accept;

  assign accept = en_rise && (dec_verd == VERD_OK);

  always_comb begin
    ctrl_d   = ctrl_q;
    a1_d     = a1_q;
    b1_d     = b1_q;
    a2_d     = a2_q;
    b2_d     = b2_q;
    r_d      = r_q;
    r_seen_d = r_seen_q;
    c_seen_d = c_seen_q;
    err_d    = err_q;
    if (en_rise) begin
      err_d = {dec_verd == VERD_LEN, dec_verd == VERD_ORD, dec_verd == VERD_RNG};
    end
    if (accept) begin
      case (dec_grp)
        GRP_CTRL: begin ctrl_d = dec_ctrl; c_seen_d = 1'b1; end
        GRP_CH1:  begin a1_d = dec_a; b1_d = dec_b; end
        GRP_CH2:  begin a2_d = dec_a; b2_d = dec_b; end
        default:  begin r_d = dec_r; r_seen_d = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q   <= '0;
      a1_q     <= '0;
      b1_q     <= '0;
      a2_q     <= '0;
      b2_q     <= '0;
      r_q      <= '0;
      r_seen_q <= 1'b0;
      c_seen_q <= 1'b0;
      err_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      a1_q     <= a1_d;
      b1_q     <= b1_d;
      a2_q     <= a2_d;
      b2_q     <= b2_d;
      r_q      <= r_d;
      r_seen_q <= r_seen_d;
      c_seen_q <= c_seen_d;
      err_q    <= err_d;
    end
  end

  assign test_mode   = ctrl_q.test;
  assign cp_invert   = ctrl_q.cp_inv;
  assign ch1_cp_code = ctrl_q.cp1;
  assign ch1_cp_sel  = 4'b0001 << ctrl_q.cp1;
  assign ch1_standby = ctrl_q.sb1;
  assign ch2_cp_code = ctrl_q.cp2;
  assign ch2_cp_sel  = 4'b0001 << ctrl_q.cp2;
  assign ch2_standby = ctrl_q.sb2;
  assign ref_standby = ctrl_q.sbr;
  assign lock_sel    = ctrl_q.ld;
  assign filt_sw     = ctrl_q.sw;
  assign ch1_swallow = a1_q;
  assign ch1_main    = b1_q;
  assign ch1_ratio   = {b1_q, a1_q, 1'b0};
  assign ch2_swallow = a2_q;
  assign ch2_main    = b2_q;
  assign ch2_ratio   = {b2_q, a2_q, 1'b0};
  assign ref_count   = r_q;
  assign ref_ratio   = {r_q, 1'b0};
  assign err_frame   = err_q[2];
  assign err_order   = err_q[1];
  assign err_range   = err_q[0];

  // R7 (also R8, R9): a refused frame leaves every latch as it was
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    en_rise && (dec_verd != VERD_OK) |=>
      $stable(ctrl_q) && $stable(r_q) && $stable(a1_q) && $stable(b1_q) &&
      $stable(a2_q) && $stable(b2_q));

  // R8
  chan_order_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !($stable(b1_q) && $stable(a1_q) && $stable(b2_q) && $stable(a2_q)) |->
      $past(r_seen_q && c_seen_q));

  // R9
  ref_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(r_q) |-> (r_q >= R_W'(R_MIN)));

  // R10
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(err_q) <= 1);

  // R4
  cp_sel_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($countones(ch1_cp_sel) == 1) && ($countones(ch2_cp_sel) == 1));

endmodule

// File: tb/tw_reg_loader_tb_top.sv
module tw_reg_loader_tb_top;

  typedef struct {
    logic [11:0] c;
    logic [4:0]  a1, a2;
    logic [11:0] b1, b2, r;
    logic [2:0]  err;
    string       tag;
  } exp_t;

  logic clk, rst_n, ser_clk, ser_data, ser_en;
  logic       test_mode, cp_invert, ch1_standby, ch2_standby, ref_standby, filt_sw;
  logic [1:0] ch1_cp_code, ch2_cp_code, lock_sel;
  logic [3:0] ch1_cp_sel, ch2_cp_sel;
  logic [4:0] ch1_swallow, ch2_swallow;
  logic [11:0] ch1_main, ch2_main, ref_count;
  logic [17:0] ch1_ratio, ch2_ratio;
  logic [12:0] ref_ratio;
  logic err_frame, err_order, err_range;

  int errors = 0;
  int checks = 0;
  exp_t model;
  exp_t exp_q[$];
  logic r_ok = 1'b0, c_ok = 1'b0;
  event chk_ev;

  tw_reg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .test_mode(test_mode), .cp_invert(cp_invert),
    .ch1_cp_code(ch1_cp_code), .ch1_cp_sel(ch1_cp_sel), .ch1_standby(ch1_standby),
    .ch2_cp_code(ch2_cp_code), .ch2_cp_sel(ch2_cp_sel), .ch2_standby(ch2_standby),
    .ref_standby(ref_standby), .lock_sel(lock_sel), .filt_sw(filt_sw),
    .ch1_swallow(ch1_swallow), .ch1_main(ch1_main), .ch1_ratio(ch1_ratio),
    .ch2_swallow(ch2_swallow), .ch2_main(ch2_main), .ch2_ratio(ch2_ratio),
    .ref_count(ref_count), .ref_ratio(ref_ratio),
    .err_frame(err_frame), .err_order(err_order), .err_range(err_range)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] rev12(input logic [11:0] v);
    for (int i = 0; i < 12; i++) rev12[i] = v[11-i];
  endfunction

  function automatic logic [4:0] rev5(input logic [4:0] v);
    for (int i = 0; i < 5; i++) rev5[i] = v[4-i];
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " R3 test"},      test_mode,   e.c[11]);
        chk({e.tag, " R3 invert"},    cp_invert,   e.c[10]);
        chk({e.tag, " R3 cp1 code"},  ch1_cp_code, e.c[9:8]);
        chk({e.tag, " R4 cp1 sel"},   ch1_cp_sel,  4'b0001 << e.c[9:8]);
        chk({e.tag, " R3 sb1"},       ch1_standby, e.c[7]);
        chk({e.tag, " R3 cp2 code"},  ch2_cp_code, e.c[6:5]);
        chk({e.tag, " R4 cp2 sel"},   ch2_cp_sel,  4'b0001 << e.c[6:5]);
        chk({e.tag, " R3 sb2/sbr"},   {ch2_standby, ref_standby}, e.c[4:3]);
        chk({e.tag, " R3 lock/sw"},   {lock_sel, filt_sw}, e.c[2:0]);
        chk({e.tag, " R1 R5 ch1 A"},  ch1_swallow, e.a1);
        chk({e.tag, " R1 R5 ch1 B"},  ch1_main,    e.b1);
        chk({e.tag, " R5 ch1 ratio"}, ch1_ratio,   2 * (32 * e.b1 + e.a1));
        chk({e.tag, " R1 R5 ch2 A"},  ch2_swallow, e.a2);
        chk({e.tag, " R1 R5 ch2 B"},  ch2_main,    e.b2);
        chk({e.tag, " R5 ch2 ratio"}, ch2_ratio,   2 * (32 * e.b2 + e.a2));
        chk({e.tag, " R6 R"},         ref_count,   e.r);
        chk({e.tag, " R6 ratio"},     ref_ratio,   2 * e.r);
        chk({e.tag, " R10 flags"},    {err_frame, err_order, err_range}, e.err);
      end
    end
  end

  // frame driver: vec[n-1] goes out first
  task automatic xmit(input logic [31:0] vec, input int n, input int junk);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = vec[i]; ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_en = 1'b1;
    repeat (3) @(negedge clk);
    for (int j = 0; j < junk; j++) begin
      ser_data = j[0]; ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    ser_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic post(input string tag, input logic [2:0] err);
    model.err = err;
    model.tag = tag;
    exp_q.push_back(model);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic ctrl_frame(input string tag, input logic [11:0] c, input int junk);
    xmit({18'd0, c, 2'b00}, 14, junk);
    model.c = c; c_ok = 1'b1;
    post(tag, 3'b000);
  endtask

  task automatic ref_frame(input string tag, input logic [11:0] r, input int junk);
    xmit({18'd0, rev12(r), 2'b11}, 14, junk);
    if (r < 3) post(tag, 3'b001);
    else begin model.r = r; r_ok = 1'b1; post(tag, 3'b000); end
  endtask

  task automatic n_frame(input string tag, input bit ch2, input logic [4:0] a,
                         input logic [11:0] b);
    xmit({13'd0, rev5(a), rev12(b), ~ch2, ch2}, 19, 0);
    if (!(r_ok && c_ok)) post(tag, 3'b010);
    else if (b < 3 || b < {7'd0, a}) post(tag, 3'b001);
    else begin
      if (ch2) begin model.a2 = a; model.b2 = b; end
      else     begin model.a1 = a; model.b1 = b; end
      post(tag, 3'b000);
    end
  endtask

  // wrong-length frame: everything held, frame flag set
  task automatic bad_len(input string tag, input logic [31:0] vec, input int n);
    xmit(vec, n, 0);
    post(tag, 3'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_en = 1'b0;
    model = '{c: '0, a1: '0, a2: '0, b1: '0, b2: '0, r: '0, err: '0, tag: ""};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    post("R11 reset", 3'b000);
    n_frame("R8 ch1 before any", 1'b0, 5'd1, 12'd100);
    ref_frame("R6 R=850", 12'd850, 0);
    n_frame("R8 ch2 without ctrl", 1'b1, 5'd2, 12'd200);
    ctrl_frame("R3 ctrl A", 12'b1_0_01_1_10_0_1_01_1, 0);
    n_frame("R5 ch1 453", 1'b0, 5'd16, 12'd1132);
    n_frame("R1 ch2 462", 1'b1, 5'd8, 12'd1157);
    ctrl_frame("R4 ctrl B", 12'b0_1_11_0_00_1_0_10_0, 0);
    ctrl_frame("R4 ctrl C", 12'b0_0_00_1_11_0_1_11_1, 0);
    bad_len("R7 long ref", {17'd0, 1'b1, rev12(12'd77), 2'b11}, 15);
    bad_len("R7 short ctrl", {19'd0, 11'h7FF, 2'b00}, 13);
    bad_len("R7 ctrl code 19 bits", {13'd0, 17'h1FFFF, 2'b00}, 19);
    ref_frame("R9 R=2", 12'd2, 0);
    n_frame("R9 B<A", 1'b0, 5'd6, 12'd5);
    n_frame("R9 B<3", 1'b1, 5'd0, 12'd2);
    n_frame("R9 B=A edge", 1'b0, 5'd3, 12'd3);
    ref_frame("R2 edges during enable", 12'd3, 3);
    ref_frame("R2 restart after junk", 12'd4095, 0);
    n_frame("R5 max", 1'b1, 5'd31, 12'd4095);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule